// File: doc/BRIEF.md
# Dual-Channel Pattern Fill Engine

The engine paints a byte range of memory with a repeating pattern. It has two channels, and each one holds its own start address, end address, pattern word and width mode. A control write with the start bit set launches a channel. The channel then covers every byte from the start address up to the end address, where the end address itself is excluded. It emits one word-wide write per granted cycle on a shared memory port, with byte enables, so a pattern of any period can begin and end at any byte. When the range is done, the channel pulses its own interrupt line and sets its finished flag.

The pattern period is 2, 3 or 4 bytes. A 3-byte colour triple does not divide a 32-bit word, so its phase drifts across word boundaries. The engine tracks that phase per channel and rebuilds each word's lanes from it. A channel launched with a zero start address writes nothing and raises no interrupt. It still passes through the closing state and sets its finished flag. If both channels are filling, a round-robin arbiter hands out the single memory port, one access per cycle.

Each channel sequencer has three states. `ST_IDLE` accepts register writes. On a start request it moves to `ST_FILL`, or goes straight to `ST_CLOSE` when the start address is zero or not below the end address. `ST_FILL` advances one word per grant and moves to `ST_CLOSE` after the word holding the last byte in range. `ST_CLOSE` lasts one cycle, pulses the interrupt when real work was requested, and returns to `ST_IDLE` with finished set.

Top module: `fill_engine`

## Requirements
- R1: After reset, `busy`, `finished`, `irq` and `mem_we` are all low.
- R2: A write with `cfg_sel`=3 and `cfg_wdata[24]`=1 to an idle channel starts it. From the next cycle that channel shows `busy`=1 and `finished`=0.
- R3: With `cfg_wdata[17:16]`=00 in the control write (16-bit mode), the byte at address a in the range receives byte ((a-start) mod 2) of the pattern word, where byte 0 is bits [7:0].
- R4: With bit 17 set and bit 16 clear (32-bit mode), the byte at address a receives pattern byte ((a-start) mod 4).
- R5: With bit 16 set (24-bit mode, which wins over bit 17), the byte at address a receives pattern byte ((a-start) mod 3). The sequence is bits [7:0], then [15:8], then [23:16].
- R6: No byte below the start address or at or above the end address is written. A start address not below the end address writes nothing.
- R7: Each access writes one word, with `mem_addr` = byte address >> 2 and lane l of `mem_be`/`mem_wdata` covering byte 4*`mem_addr`+l. `mem_be` is never zero. A single channel visits each word of its range once, in ascending order.
- R8: A start address of zero writes no memory and raises no interrupt. The channel still clears `busy` and sets `finished`.
- R9: A fill with a nonzero start address pulses that channel's `irq` for exactly one cycle. On the following cycle `busy` is 0 and `finished` is 1.
- R10: While a channel is busy, every write to its registers is ignored, a second start request included.
- R11: `finished` stays set until the channel is started again, and is cleared by that start.
- R12: While both channels are filling, the memory port alternates between them on consecutive cycles.
- R13: A channel's fill raises only its own `irq` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_sel | input | 2 | 0 start address, 1 end address, 2 pattern word, 3 control |
| cfg_wdata | input | 32 | Write data; control uses bit 16 (24-bit), bit 17 (32-bit), bit 24 (start) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane l in bits [8l+7:8l] |
| irq | output | 2 | One-cycle completion pulse per channel |
| busy | output | 2 | Channel not idle |
| finished | output | 2 | Channel has completed since its last start |

## Verification
The sweep covers every start offset within a few words, range lengths from zero to several words, and all four mode codes. Getting the 3-byte phase carry wrong garbles colours after the first word boundary. Getting the end test wrong writes the byte at the end address. Dropping the mode priority turns the both-bits case into a 4-byte period. The zero-start, reversed-range and busy-write cases catch a design that writes memory when it should not, misses or duplicates an interrupt, or lets a mid-fill write corrupt the stored setup. The two-channel run checks the write order and catches an arbiter that lets one channel finish before the other starts.

// File: rtl/fill_pkg.sv
package fill_pkg;

    localparam int NCH       = 2;
    localparam int SEL_START = 0;
    localparam int SEL_END   = 1;
    localparam int SEL_VALUE = 2;
    localparam int SEL_CTRL  = 3;
    localparam int CTRL_M24  = 16;
    localparam int CTRL_M32  = 17;
    localparam int CTRL_GO   = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_CLOSE
    } chan_state_t;

    // reduce a small byte offset to the pattern phase of the active mode
    function automatic logic [1:0] wrap_phase(input logic [2:0] x,
                                              input logic m24,
                                              input logic m32);
        logic [1:0] r;
        if (m24) begin
            if (x >= 3'd6)      r = 2'(x - 3'd6);
            else if (x >= 3'd3) r = 2'(x - 3'd3);
            else                r = x[1:0];
        end else if (m32) begin
            r = x[1:0];
        end else begin
            r = {1'b0, x[0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/fill_arb.sv
module fill_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] gnt
);

    logic last_id;

    always_comb begin
        unique case (req)
            2'b00:   gnt = 2'b00;
            2'b01:   gnt = 2'b01;
            2'b10:   gnt = 2'b10;
            default: gnt = last_id ? 2'b01 : 2'b10;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_id <= 1'b1;
        else if (|gnt)   last_id <= gnt[1];
    end

endmodule

// File: rtl/fill_chan.sv
module fill_chan
    import fill_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              gnt,
    output logic              req,
    output logic              busy,
    output logic              finished,
    output logic              irq,
    output logic [ADDR_W-3:0] acc_word,
    output logic [3:0]        acc_be,
    output logic [31:0]       acc_data
);

    localparam int PW = ADDR_W + 1;

    chan_state_t       st, st_nx;
    logic [ADDR_W-1:0] r_start, r_end;
    logic [31:0]       r_val;
    logic              r_m24, r_m32;
    logic [PW-1:0]     ptr;
    logic [1:0]        ph;
    logic              r_real, r_fin;

    logic              cfg_ok, go_wr, skip;
    logic [1:0]        off;
    logic [PW-1:0]     wbase, lane_addr, nxt_ptr;
    logic [2:0]        lane_k, step;
    logic [1:0]        lane_p, nxt_ph;
    logic              last;

    assign cfg_ok = wr_en && (st == ST_IDLE);
    assign go_wr  = cfg_ok && (wr_sel == 2'(SEL_CTRL)) && wr_data[CTRL_GO];
    assign skip   = (r_start == '0) || (r_start >= r_end);

    // word access built from the byte pointer and pattern phase
    always_comb begin
        off      = ptr[1:0];
        wbase    = {ptr[PW-1:2], 2'b00};
        acc_be   = '0;
        acc_data = '0;
        lane_addr = '0;
        lane_k    = '0;
        lane_p    = '0;
        for (int l = 0; l < 4; l++) begin
            lane_addr = wbase + PW'(l);
            lane_k    = 3'(l) - {1'b0, off};
            lane_p    = wrap_phase({1'b0, ph} + lane_k, r_m24, r_m32);
            acc_be[l] = (2'(l) >= off) && (lane_addr < {1'b0, r_end});
            acc_data[8*l +: 8] = r_val[{lane_p, 3'b000} +: 8];
        end
        step     = 3'd4 - {1'b0, off};
        nxt_ph   = wrap_phase({1'b0, ph} + step, r_m24, r_m32);
        nxt_ptr  = wbase + PW'(4);
        last     = nxt_ptr >= {1'b0, r_end};
        acc_word = ptr[ADDR_W-1:2];
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (go_wr)        st_nx = skip ? ST_CLOSE : ST_FILL;
            ST_FILL:  if (gnt && last)  st_nx = ST_CLOSE;
            ST_CLOSE:                   st_nx = ST_IDLE;
            default:                    st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // configuration and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_start <= '0;
            r_end   <= '0;
            r_val   <= '0;
            r_m24   <= 1'b0;
            r_m32   <= 1'b0;
            ptr     <= '0;
            ph      <= '0;
            r_real  <= 1'b0;
            r_fin   <= 1'b0;
        end else begin
            if (cfg_ok) begin
                unique case (wr_sel)
                    2'(SEL_START): r_start <= wr_data[ADDR_W-1:0];
                    2'(SEL_END):   r_end   <= wr_data[ADDR_W-1:0];
                    2'(SEL_VALUE): r_val   <= wr_data;
                    default: begin
                        r_m24 <= wr_data[CTRL_M24];
                        r_m32 <= wr_data[CTRL_M32];
                    end
                endcase
            end
            if (go_wr) begin
                ptr    <= {1'b0, r_start};
                ph     <= '0;
                r_real <= (r_start != '0);
                r_fin  <= 1'b0;
            end
            if ((st == ST_FILL) && gnt) begin
                ptr <= nxt_ptr;
                ph  <= nxt_ph;
            end
            if (st == ST_CLOSE) r_fin <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        req      = (st == ST_FILL);
        busy     = (st != ST_IDLE);
        irq      = (st == ST_CLOSE) && r_real;
        finished = r_fin;
    end

endmodule

// File: rtl/fill_engine.sv
module fill_engine
    import fill_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic [1:0]        irq,
    output logic [1:0]        busy,
    output logic [1:0]        finished
);

    localparam int WA_W = ADDR_W - 2;

    logic [NCH-1:0] req, gnt;
    logic [WA_W-1:0] acc_word [NCH];
    logic [3:0]      acc_be   [NCH];
    logic [31:0]     acc_data [NCH];
    logic            src;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        fill_chan #(.ADDR_W(ADDR_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_ch == 1'(g))),
            .wr_sel   (cfg_sel),
            .wr_data  (cfg_wdata),
            .gnt      (gnt[g]),
            .req      (req[g]),
            .busy     (busy[g]),
            .finished (finished[g]),
            .irq      (irq[g]),
            .acc_word (acc_word[g]),
            .acc_be   (acc_be[g]),
            .acc_data (acc_data[g])
        );
    end

    fill_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    assign src = gnt[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= |gnt;
            mem_addr  <= acc_word[src];
            mem_be    <= (|gnt) ? acc_be[src] : 4'b0000;
            mem_wdata <= acc_data[src];
        end
    end

endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       cfg_ch,
    input logic [1:0] cfg_sel,
    input logic       go_bit,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic [1:0] irq,
    input logic [1:0] busy,
    input logic [1:0] finished,
    input logic [1:0] req,
    input logic [1:0] gnt
);

    // R7
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != 4'b0000));

    // R7
    write_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(|req));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3 && go_bit && !busy[cfg_ch])
        |=> (busy[$past(cfg_ch)] && !finished[$past(cfg_ch)]));

    // R9
    close0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |=> (!busy[0] && finished[0] && !irq[0]));

    // R9
    close1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |=> (!busy[1] && finished[1] && !irq[1]));

    // R12
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && $past(req) == 2'b11) |-> (gnt != $past(gnt)));

    // R1
    always @(posedge clk) begin
        if (!rst_n) reset_chk: assert (busy == 2'b00 && finished == 2'b00 && !mem_we);
    end

endmodule

bind fill_engine fill_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_ch   (cfg_ch),
    .cfg_sel  (cfg_sel),
    .go_bit   (cfg_wdata[24]),
    .mem_we   (mem_we),
    .mem_be   (mem_be),
    .irq      (irq),
    .busy     (busy),
    .finished (finished),
    .req      (req),
    .gnt      (gnt)
);

// File: tb/fill_engine_tb.sv
`timescale 1ns/1ps
module fill_engine_tb;

    localparam int AW   = 8;
    localparam int MEMB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_ch = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          mem_we;
    logic [AW-3:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [1:0]    irq, busy, finished;

    always #4 clk = ~clk;

    fill_engine #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .irq(irq), .busy(busy), .finished(finished)
    );

    logic [7:0] mem_img [MEMB];
    logic [7:0] exp_img [MEMB];
    int checks = 0, errors = 0, cyc = 0;
    int irq_cnt [2];
    int wr_cnt, last_word, order_bad;
    int wr_log [64];

    // memory model and event monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem_img[int'(mem_addr) * 4 + l] = mem_wdata[8*l +: 8];
                if (int'(mem_addr) <= last_word || mem_be == 4'b0000) order_bad++;
                last_word = int'(mem_addr);
                if (wr_cnt < 64) wr_log[wr_cnt] = int'(mem_addr);
                wr_cnt++;
            end
            if (irq[0]) irq_cnt[0]++;
            if (irq[1]) irq_cnt[1]++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input int sel, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] pat(input logic [31:0] v, input bit m24,
                                       input bit m32, input int k);
        int p;
        p = m24 ? 3 : (m32 ? 4 : 2);
        return v[8*(k % p) +: 8];
    endfunction

    function automatic logic [31:0] ctrl_word(input bit m24, input bit m32);
        return (32'(m24) << 16) | (32'(m32) << 17) | (32'h1 << 24);
    endfunction

    task automatic prog(input int ch, input int s, input int e, input logic [31:0] v);
        cfg_write(ch, 0, 32'(s));
        cfg_write(ch, 1, 32'(e));
        cfg_write(ch, 2, v);
    endtask

    task automatic clear_counts();
        irq_cnt[0] = 0; irq_cnt[1] = 0;
        wr_cnt = 0; last_word = -1; order_bad = 0;
    endtask

    // starts a channel whose registers already hold s/e/v and checks the result
    task automatic go(input int ch, input int s, input int e, input logic [31:0] v,
                      input bit m24, input bit m32, input bit poke, input string tag);
        int bad, words, first_bad;
        for (int a = 0; a < MEMB; a++) exp_img[a] = mem_img[a];
        if (s != 0)
            for (int a = s; a < e; a++) exp_img[a] = pat(v, m24, m32, a - s);
        words = (s != 0 && s < e) ? (((e - 1) >> 2) - (s >> 2) + 1) : 0;
        clear_counts();
        cfg_write(ch, 3, ctrl_word(m24, m32));
        // R2 R11: running and finished cleared right after the start
        check(busy[ch] == 1'b1 && finished[ch] == 1'b0, "R2/R11 start",
              {busy[ch], finished[ch]}, 2'b10);
        if (poke) begin
            // R10: all ignored while busy
            cfg_write(ch, 0, 32'h10);
            cfg_write(ch, 2, 32'h0);
            cfg_write(ch, 3, ctrl_word(1'b0, 1'b0));
        end
        for (int i = 0; i < 400 && busy[ch]; i++) begin
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
        bad = 0; first_bad = -1;
        for (int a = 0; a < MEMB; a++)
            if (mem_img[a] !== exp_img[a]) begin
                bad++;
                if (first_bad < 0) first_bad = a;
            end
        check(bad == 0, tag, first_bad < 0 ? 0 : int'(mem_img[first_bad]),
              first_bad < 0 ? 0 : int'(exp_img[first_bad]));
        check(wr_cnt == words && order_bad == 0, "R7 word count/order", wr_cnt, words);
        check(irq_cnt[ch] == ((s != 0) ? 1 : 0) && irq_cnt[1-ch] == 0,
              "R9/R8/R13 irq", irq_cnt[ch] * 16 + irq_cnt[1-ch], (s != 0) ? 16 : 0);
        check(busy[ch] == 1'b0 && finished[ch] == 1'b1, "R9 finished", {busy[ch], finished[ch]}, 2'b01);
    endtask

    initial begin
        for (int a = 0; a < MEMB; a++) mem_img[a] = 8'(a * 7 + 1);
        clear_counts();
        repeat (3) @(posedge clk);
        #2;
        // R1
        check(busy == 2'b00 && finished == 2'b00 && irq == 2'b00 && !mem_we,
              "R1 reset", {busy, finished, irq}, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(busy == 2'b00 && finished == 2'b00 && !mem_we, "R1 after release",
              {busy, finished}, 0);

        // R3 R4 R5 R6 sweep: mode code, start offset and length
        for (int md = 0; md < 4; md++) begin
            for (int s = 1; s < 13; s++) begin
                for (int len = 0; len < 12; len++) begin
                    logic [31:0] v;
                    bit m24, m32;
                    m24 = (md & 1) != 0;
                    m32 = (md & 2) != 0;
                    v = 32'hA1B2C3D4 ^ 32'(s * 97 + len * 13 + md);
                    prog(s % 2, s, s + len, v);
                    go(s % 2, s, s + len, v, m24, m32, 1'b0,
                       m24 ? "R5/R6 24-bit" : (m32 ? "R4/R6 32-bit" : "R3/R6 16-bit"));
                end
            end
        end

        // R6: reversed range, and a range at the top of the address space
        prog(0, 20, 10, 32'h11223344);
        go(0, 20, 10, 32'h11223344, 1'b0, 1'b1, 1'b0, "R6 reversed");
        prog(1, 249, 255, 32'h00C0FFEE);
        go(1, 249, 255, 32'h00C0FFEE, 1'b1, 1'b0, 1'b0, "R6/R5 top");

        // R8: zero start
        prog(0, 0, 16, 32'hDEADBEEF);
        go(0, 0, 16, 32'hDEADBEEF, 1'b0, 1'b1, 1'b0, "R8 zero start");

        // R10: writes during a fill are dropped; a bare restart reuses the setup
        prog(0, 64, 104, 32'h5566AA99);
        go(0, 64, 104, 32'h5566AA99, 1'b0, 1'b1, 1'b1, "R10 busy writes");
        for (int a = 64; a < 104; a++) mem_img[a] = 8'h00;
        go(0, 64, 104, 32'h5566AA99, 1'b0, 1'b1, 1'b0, "R10 stored setup");

        // R12: both channels at once
        begin
            int alt_bad, bad;
            prog(0, 0 + 4, 36, 32'h01020304);
            prog(1, 128, 160, 32'hF0E0D0C0);
            for (int a = 0; a < MEMB; a++) exp_img[a] = mem_img[a];
            for (int a = 4; a < 36; a++) exp_img[a] = pat(32'h01020304, 1'b0, 1'b1, a - 4);
            for (int a = 128; a < 160; a++) exp_img[a] = pat(32'hF0E0D0C0, 1'b0, 1'b1, a - 128);
            clear_counts();
            last_word = 999;
            cfg_write(0, 3, ctrl_word(1'b0, 1'b1));
            cfg_write(1, 3, ctrl_word(1'b0, 1'b1));
            for (int i = 0; i < 400 && busy != 2'b00; i++) begin
                @(posedge clk); #2;
            end
            @(posedge clk); #2;
            alt_bad = 0;
            for (int i = 2; i < 15; i++)
                if ((wr_log[i] >= 32) == (wr_log[i-1] >= 32)) alt_bad++;
            check(alt_bad == 0 && wr_cnt == 16, "R12 alternation", alt_bad * 256 + wr_cnt, 16);
            bad = 0;
            for (int a = 0; a < MEMB; a++) if (mem_img[a] !== exp_img[a]) bad++;
            check(bad == 0, "R12/R4 both contents", bad, 0);
            check(irq_cnt[0] == 1 && irq_cnt[1] == 1 && finished == 2'b11,
                  "R13/R9 both irqs", irq_cnt[0] * 16 + irq_cnt[1], 17);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule